// File: doc/BRIEF.md
# Memory Controller Control Latch with Power-Supply Interrupt Collector

This block is an eight-bit control register written from the CPU bus. Software cannot read it back. It drives two active-low lines of a DRAM controller (refresh disable and mode) and two plain lines toward the power-supply connector. It also merges three power-supply interrupt sources into one interrupt request for level 1. Two of the sources can be masked through register bits and the third cannot. All three share a single sticky request flip-flop. A bus read of the register's address clears that flip-flop.

The register is loaded from the upper byte of the CPU data bus with the bit order reversed: register bit `i` takes bus-byte bit `7-i`. A timer channel drives an active-low output-enable input. While that input is high the register outputs are treated as floating. This is modelled by a valid flag, and the outputs are driven to zero while the flag is low. Source inputs are asynchronous, so each one passes through a synchronizer. A source sets the request only on a rising edge and only while it is unmasked.

Top module: `memctl_ctrl_latch`

## Requirements
- R1: On a clock edge where `bus_sel` and `bus_wr` are both 1, register bit `i` is loaded from `bus_data_hi[7-i]`. A write strobe with `bus_sel` at 0 leaves the register unchanged.
- R2: Register bit 5 drives `refresh_dis_n`, bit 4 drives `mode_n`, bit 3 drives `psu_ctl[1]` and bit 2 drives `psu_ctl[0]`. Bits 7 and 6 reach no output.
- R3: The outputs are registered and follow `oe_n` one edge later. When `oe_n` is 1, `out_valid` is 0 and all four control outputs are 0. When `oe_n` is 0, `out_valid` is 1 and the outputs show the register. The register contents survive a period with `oe_n` high.
- R4: A synchronous reset (`rst` = 1) clears the register, the control outputs and `irq_lvl1`.
- R5: A rising edge on an unmasked `psu_src` input sets `irq_lvl1` on the third rising clock edge after the input changes (two synchronizer stages plus the edge detector). `irq_lvl1` then stays 1 until it is cleared.
- R6: Register bit 0 masks `psu_src[0]` and bit 1 masks `psu_src[1]`, where 1 means masked. An edge on a masked source does not set `irq_lvl1`.
- R7: `psu_src[2]` has no mask bit. Its rising edge sets `irq_lvl1` whatever the register value is.
- R8: A clock edge with `bus_sel` and `bus_rd` both 1 clears `irq_lvl1` and leaves the register unchanged.
- R9: When a qualifying source edge and a clearing read fall on the same clock edge, the set wins and `irq_lvl1` is 1 afterwards.
- R10: A source that stays high after a clear does not set `irq_lvl1` again until it has gone low and risen once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register address selected (active high) |
| bus_rd | input | 1 | Read strobe; clears the interrupt request |
| bus_wr | input | 1 | Write strobe; loads the register |
| bus_data_hi | input | 8 | Upper byte of the CPU data bus |
| oe_n | input | 1 | Active-low output enable from the timer channel |
| psu_src | input | 3 | Power-supply interrupt sources; [1:0] maskable, [2] not |
| refresh_dis_n | output | 1 | DRAM controller refresh disable, active low |
| mode_n | output | 1 | DRAM controller mode line, active low |
| psu_ctl | output | 2 | Plain lines to the power-supply connector |
| out_valid | output | 1 | Control outputs are driven (not floating) |
| irq_lvl1 | output | 1 | Shared interrupt request, level 1 |

## Verification
A source edge reaching the request flip-flop and a clearing read can fall on the same clock edge. The bench provokes this by counting clock edges from the moment a source rises and placing the read strobe so that it is sampled on exactly the third edge. The result is judged by expecting `irq_lvl1` to be 1 after that edge. A following read with no source activity must then drop it to 0.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  localparam int unsigned CTRL_W = 8;

  // register bit positions the neighbours decode
  localparam int unsigned BIT_MASK0   = 0;
  localparam int unsigned BIT_MASK1   = 1;
  localparam int unsigned BIT_PSU_LO  = 2;
  localparam int unsigned BIT_PSU_HI  = 3;
  localparam int unsigned BIT_MODE    = 4;
  localparam int unsigned BIT_RFSH    = 5;

  typedef struct packed {
    logic       refresh_dis_n;
    logic       mode_n;
    logic [1:0] psu_ctl;
  } ctrl_out_t;

  function automatic logic [CTRL_W-1:0] bit_reverse(input logic [CTRL_W-1:0] v);
    logic [CTRL_W-1:0] r;
    for (int i = 0; i < CTRL_W; i++) r[i] = v[CTRL_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/memctl_bus_decode.sv
module memctl_bus_decode #(
  parameter int unsigned W = 8
) (
  input  logic         bus_sel,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_data,
  output logic         wr_stb,
  output logic         rd_stb,
  output logic [W-1:0] wr_byte
);

  assign wr_stb = bus_sel & bus_wr;
  assign rd_stb = bus_sel & bus_rd;

  // data lines land on the register in reverse order
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign wr_byte[g] = bus_data[W-1-g];
  end

endmodule

// File: rtl/memctl_ctrl_reg.sv
module memctl_ctrl_reg
  import memctl_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         oe_n,
  output logic [W-1:0] ctrl_q,
  output ctrl_out_t    outs,
  output logic         out_valid
);

  logic [W-1:0] ctrl_d;
  ctrl_out_t    outs_d;

  always_comb begin
    ctrl_d = wr_stb ? wr_byte : ctrl_q;
    outs_d = '0;
    if (!oe_n) begin
      outs_d.refresh_dis_n = ctrl_d[BIT_RFSH];
      outs_d.mode_n        = ctrl_d[BIT_MODE];
      outs_d.psu_ctl       = ctrl_d[BIT_PSU_HI:BIT_PSU_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      outs      <= '0;
      out_valid <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      outs      <= outs_d;
      out_valid <= ~oe_n;
    end
  end

  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!out_valid && outs == '0)); // R3
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(ctrl_q)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && outs == '0)); // R4

endmodule

// File: rtl/memctl_irq_collect.sv
module memctl_irq_collect #(
  parameter int unsigned N_SRC       = 3,
  parameter int unsigned N_MASK      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src,
  input  logic [N_MASK-1:0] mask,
  input  logic              clr,
  output logic              irq
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N_SRC-1:0] synced;
  logic [N_SRC-1:0] prev;
  logic [N_SRC-1:0] hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[SYNC_STAGES-2:0], src[s]};
    end
    assign synced[s] = chain[LAST];

    if (s < N_MASK) begin : g_maskable
      assign hit[s] = synced[s] & ~prev[s] & ~mask[s];
    end else begin : g_fixed
      assign hit[s] = synced[s] & ~prev[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      irq  <= 1'b0;
    end else begin
      prev <= synced;
      if (|hit)     irq <= 1'b1;  // set beats clear
      else if (clr) irq <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> irq); // R9
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|hit)) |=> !irq); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq); // R5
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(|(synced & ~prev))) |=> !irq); // R10

endmodule

// File: rtl/memctl_ctrl_latch.sv
module memctl_ctrl_latch
  import memctl_pkg::*;
#(
  parameter int unsigned N_SRC       = 3,
  parameter int unsigned N_MASK      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [7:0]       bus_data_hi,
  input  logic             oe_n,
  input  logic [N_SRC-1:0] psu_src,
  output logic             refresh_dis_n,
  output logic             mode_n,
  output logic [1:0]       psu_ctl,
  output logic             out_valid,
  output logic             irq_lvl1
);

  localparam int unsigned W = CTRL_W;

  logic         wr_stb;
  logic         rd_stb;
  logic [W-1:0] wr_byte;
  logic [W-1:0] ctrl_q;
  ctrl_out_t    outs;

  memctl_bus_decode #(.W(W)) u_dec (
    .bus_sel (bus_sel),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_data(bus_data_hi),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .wr_byte (wr_byte)
  );

  memctl_ctrl_reg #(.W(W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .oe_n     (oe_n),
    .ctrl_q   (ctrl_q),
    .outs     (outs),
    .out_valid(out_valid)
  );

  memctl_irq_collect #(
    .N_SRC      (N_SRC),
    .N_MASK     (N_MASK),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_irq (
    .clk (clk),
    .rst (rst),
    .src (psu_src),
    .mask(ctrl_q[BIT_MASK0 +: N_MASK]),
    .clr (rd_stb),
    .irq (irq_lvl1)
  );

  assign refresh_dis_n = outs.refresh_dis_n;
  assign mode_n        = outs.mode_n;
  assign psu_ctl       = outs.psu_ctl;

  AST_REVERSED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr) |=> (ctrl_q == bit_reverse($past(bus_data_hi)))); // R1
  AST_UNSELECTED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel) |=> $stable(ctrl_q)); // R1
  AST_IRQ_RESET: assert property (@(posedge clk)
    rst |=> !irq_lvl1); // R4

endmodule

// File: tb/memctl_ctrl_latch_bench.sv
module memctl_ctrl_latch_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_data_hi = '0;
  logic       oe_n = 1'b0;
  logic [2:0] psu_src = '0;
  logic       refresh_dis_n, mode_n, out_valid, irq_lvl1;
  logic [1:0] psu_ctl;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 1'b0;

  always #2 clk = ~clk;

  memctl_ctrl_latch u_memctl_ctrl_latch (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_data_hi(bus_data_hi), .oe_n(oe_n), .psu_src(psu_src),
    .refresh_dis_n(refresh_dis_n), .mode_n(mode_n), .psu_ctl(psu_ctl),
    .out_valid(out_valid), .irq_lvl1(irq_lvl1)
  );

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // expected visible outputs {valid, rfsh, mode, psu[1:0]} from a bus byte
  function automatic int expect_outs(input logic [7:0] bus, input bit valid);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = bus[7-i];
    if (!valid) return 0;
    return {1'b1, r[5], r[4], r[3], r[2]};
  endfunction

  function automatic int outs_now();
    return {out_valid, refresh_dis_n, mode_n, psu_ctl};
  endfunction

  task automatic bus_write(input logic [7:0] d, input logic sel);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_data_hi = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_data_hi = '0;
  endtask

  task automatic bus_read();
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // raise a source, check irq timing, then drop it and let it settle
  task automatic src_pulse(input int idx, input bit expect_set, input string tag);
    @(negedge clk);
    psu_src[idx] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({tag, " irq before third edge"}, irq_lvl1, 0);
    @(negedge clk);
    check({tag, " irq after third edge"}, irq_lvl1, expect_set);
    psu_src[idx] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R4 outputs after reset", outs_now(), expect_outs(8'h00, 1'b1));
    check("R4 irq after reset", irq_lvl1, 0);
  endtask

  task automatic t_fields();
    bus_write(8'h04, 1'b1);
    check("R1 R2 bus bit2 -> refresh_dis_n", outs_now(), expect_outs(8'h04, 1'b1));
    bus_write(8'h08, 1'b1);
    check("R1 R2 bus bit3 -> mode_n", outs_now(), expect_outs(8'h08, 1'b1));
    bus_write(8'h10, 1'b1);
    check("R2 bus bit4 -> psu_ctl[1]", outs_now(), expect_outs(8'h10, 1'b1));
    bus_write(8'h20, 1'b1);
    check("R2 bus bit5 -> psu_ctl[0]", outs_now(), expect_outs(8'h20, 1'b1));
    bus_write(8'h03, 1'b1);
    check("R2 unused bits reach no output", outs_now(), 5'b10000);
    bus_write(8'h3C, 1'b1);
    bus_write(8'h00, 1'b0);
    check("R1 unselected write ignored", outs_now(), expect_outs(8'h3C, 1'b1));
  endtask

  task automatic t_oe();
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    check("R3 floating outputs zero", outs_now(), 0);
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    check("R3 outputs restored", outs_now(), expect_outs(8'h3C, 1'b1));
  endtask

  task automatic t_irq_basic();
    bus_write(8'h00, 1'b1);
    src_pulse(0, 1'b1, "R5 src0");
    bus_read();
    check("R8 read clears irq", irq_lvl1, 0);
    check("R8 read keeps register", outs_now(), expect_outs(8'h00, 1'b1));
  endtask

  task automatic t_edge_only();
    @(negedge clk); psu_src[1] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 first rise sets", irq_lvl1, 1);
    bus_read();
    repeat (6) @(negedge clk);
    check("R10 held level does not re-set", irq_lvl1, 0);
    psu_src[1] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_mask();
    bus_write(8'h80, 1'b1);
    src_pulse(0, 1'b0, "R6 src0 masked");
    src_pulse(1, 1'b1, "R6 src1 unmasked");
    bus_read();
    bus_write(8'h40, 1'b1);
    src_pulse(1, 1'b0, "R6 src1 masked");
    src_pulse(0, 1'b1, "R6 src0 unmasked");
    bus_read();
  endtask

  task automatic t_nmi();
    bus_write(8'hC0, 1'b1);
    src_pulse(2, 1'b1, "R7 src2 unmaskable");
    bus_read();
    check("R7 cleared", irq_lvl1, 0);
  endtask

  task automatic t_collide();
    @(negedge clk); psu_src[2] = 1'b1;
    @(negedge clk);            // after first edge
    @(negedge clk);            // after second edge
    bus_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);            // third edge: set and clear together
    bus_sel = 1'b0; bus_rd = 1'b0;
    check("R9 set wins over clear", irq_lvl1, 1);
    psu_src[2] = 1'b0;
    bus_read();
    check("R9 later read clears", irq_lvl1, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_oe();
    t_irq_basic();
    t_edge_only();
    t_mask();
    t_nmi();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule